// File: doc/BRIEF.md
# Converter Result Hold Register with Read Lock

This block sits between a 10-bit converter and a byte-wide register bus. Each completed conversion arrives as a one-cycle done strobe together with a 10-bit value. The block keeps the raw value and shows it as a low and a high readable byte. A justify control chooses the layout. Right justification puts the value in the low byte plus the two lowest bits of the high byte. Left justification puts the top eight bits in the high byte, so software that needs only 8-bit precision reads a single byte.

To stop a value from tearing across two byte reads, a low-byte read locks the pair. While the lock is held, finished conversions are discarded. A high-byte read releases the lock. Every finished conversion sets a completion flag, including one that was discarded. Software clears the flag by writing 1. The interrupt output is the flag gated by an interrupt enable. When the enable control is clear, no conversions are accepted, any lock is released and the flag is cleared.

The lock state machine has two states. `ST_OPEN` means results may be written. `ST_HELD` means results are dropped. Transition `T_LOCK` (`ST_OPEN`→`ST_HELD`) fires on a low-byte read without a high-byte read while enabled. Transition `T_RELEASE` (`ST_HELD`→`ST_OPEN`) fires on a high-byte read. Transition `T_ABORT` (`ST_HELD`→`ST_OPEN`) fires when enable is clear. In every other case the state stays the same.

Top module: `adc_result_lock`

## Requirements
- R1: With `left_adj`=0, `lo_byte` = value[7:0] and `hi_byte` = {6'b0, value[9:8]}.
- R2: With `left_adj`=1, `hi_byte` = value[9:2] and `lo_byte` = {value[1:0], 6'b0}.
- R3: In `ST_OPEN` with `enable`=1, a `conv_done` pulse without `rd_lo` stores `conv_data`. The new value shows on the byte outputs from the cycle after the edge.
- R4: A `rd_lo` pulse without `rd_hi` while `enable`=1 enters `ST_HELD` at the next edge. A conversion that completes in the same cycle as that `rd_lo` is discarded.
- R5: While in `ST_HELD`, completed conversions leave both byte outputs unchanged.
- R6: `rd_hi` in `ST_HELD` returns to `ST_OPEN`, and later conversions are stored again. `rd_hi` in `ST_OPEN` has no effect on the state.
- R7: Every `conv_done` while `enable`=1 sets `flag` at the next edge, whether the result was stored or discarded. `irq` = `flag` AND `irq_en`.
- R8: A `flag_clr` pulse clears `flag`. If a conversion completes in the same cycle, setting wins.
- R9: With `enable`=0, conversions are ignored and `flag` is cleared. A held lock is released at the next edge. Reset clears the stored value to 0, clears `flag` and selects `ST_OPEN`.
- R10: Changing `left_adj` re-maps the held value immediately, without a new conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Block enable |
| left_adj | input | 1 | 1 selects left justification |
| irq_en | input | 1 | Interrupt enable |
| conv_done | input | 1 | Conversion finished strobe |
| conv_data | input | 10 | Converted value |
| rd_lo | input | 1 | Low-byte bus read strobe |
| rd_hi | input | 1 | High-byte bus read strobe |
| flag_clr | input | 1 | Write-1 clear of the completion flag |
| lo_byte | output | 8 | Low result byte |
| hi_byte | output | 8 | High result byte |
| flag | output | 1 | Completion flag |
| irq | output | 1 | Interrupt request |

## Verification
Values whose upper and lower bits differ (0x2A5, 0x13C) are shown in both justifications. This tells a swapped byte from a wrong shift, and the extreme values 0x000, 0x3FF, 0x200 and 0x001 expose stray or missing bits at the byte seam. Conversions are placed inside a lock, in the same cycle as the locking read, right after the releasing read, and against a disable. These placements separate a missing lock, an early or late release and a lost abort. Flag clears are tried alone and against a coincident conversion, and `irq_en` is toggled around a set flag.

// File: rtl/adc_lock_pkg.sv
package adc_lock_pkg;
    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } lock_state_t;
endpackage

// File: rtl/adc_lock_fsm.sv
module adc_lock_fsm
    import adc_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic conv_done,
    input  logic rd_lo,
    input  logic rd_hi,
    output logic held,
    output logic accept
);
    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPEN: if (enable && rd_lo && !rd_hi) state_d = ST_HELD;   // T_LOCK
            ST_HELD: if (!enable || rd_hi)          state_d = ST_OPEN;   // T_ABORT / T_RELEASE
            default:                                state_d = ST_OPEN;
        endcase
    end

    always_comb begin
        held   = (state_q == ST_HELD);
        accept = enable && conv_done && (state_q == ST_OPEN) && !rd_lo;
    end

    AST_LOCK_ON_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && rd_lo && !rd_hi) |=> held); // R4
    AST_RELEASE_ON_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (held && rd_hi) |=> !held); // R6
    AST_DISABLE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !held); // R9
endmodule

// File: rtl/adc_result_store.sv
module adc_result_store #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] raw_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     raw_q <= '0;
        else if (wr_en) raw_q <= wr_data;
    end
endmodule

// File: rtl/adc_justify.sv
module adc_justify #(
    parameter int DATA_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              left_adj,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte
);
    localparam int WIDE_W = 2 * BYTE_W;
    localparam int PAD    = WIDE_W - DATA_W;

    logic [WIDE_W-1:0] wide;

    always_comb begin
        wide = WIDE_W'(raw);
        if (left_adj) wide = wide << PAD;
        lo_byte = wide[BYTE_W-1:0];
        hi_byte = wide[WIDE_W-1:BYTE_W];
    end
endmodule

// File: rtl/adc_irq_flag.sv
module adc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic conv_done,
    input  logic flag_clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    flag <= 1'b0;
        else if (!enable)              flag <= 1'b0;
        else if (conv_done)            flag <= 1'b1;
        else if (flag_clr)             flag <= 1'b0;
    end

    AST_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && conv_done) |=> flag); // R7
    AST_CLR_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !conv_done) |=> !flag); // R8
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !flag); // R9
endmodule

// File: rtl/adc_result_lock.sv
module adc_result_lock #(
    parameter int DATA_W = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              left_adj,
    input  logic              irq_en,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              rd_lo,
    input  logic              rd_hi,
    input  logic              flag_clr,
    output logic [BYTE_W-1:0] lo_byte,
    output logic [BYTE_W-1:0] hi_byte,
    output logic              flag,
    output logic              irq
);
    logic              held;
    logic              accept;
    logic [DATA_W-1:0] raw_q;

    adc_lock_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .conv_done(conv_done),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .held(held), .accept(accept)
    );

    adc_result_store #(.DATA_W(DATA_W)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_data(conv_data), .raw_q(raw_q)
    );

    adc_justify #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) i_just (
        .raw(raw_q), .left_adj(left_adj), .lo_byte(lo_byte), .hi_byte(hi_byte)
    );

    adc_irq_flag i_flag (
        .clk(clk), .rst_n(rst_n), .enable(enable), .conv_done(conv_done),
        .flag_clr(flag_clr), .flag(flag)
    );

    assign irq = flag & irq_en;

    AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (held && conv_done) |=> $stable(raw_q)); // R5
    AST_OPEN_STORES: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && enable && conv_done && !rd_lo) |=> (raw_q == $past(conv_data))); // R3
    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(raw_q)); // R9
endmodule

// File: tb/test_adc_result_lock.sv
module test_adc_result_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0, left_adj = 1'b0, irq_en = 1'b0;
    logic       conv_done = 1'b0, rd_lo = 1'b0, rd_hi = 1'b0, flag_clr = 1'b0;
    logic [9:0] conv_data = '0;
    logic [7:0] lo_byte, hi_byte;
    logic       flag, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        string      tag;
        logic [7:0] lo;
        logic [7:0] hi;
        logic       fl;
        logic       iq;
    } exp_t;
    exp_t sb[$];

    // bench reference state
    logic [9:0] m_raw  = '0;
    logic       m_lock = 1'b0;
    logic       m_flag = 1'b0;

    always #5 clk = ~clk;

    adc_result_lock i_adc_result_lock (
        .clk(clk), .rst_n(rst_n), .enable(enable), .left_adj(left_adj),
        .irq_en(irq_en), .conv_done(conv_done), .conv_data(conv_data),
        .rd_lo(rd_lo), .rd_hi(rd_hi), .flag_clr(flag_clr),
        .lo_byte(lo_byte), .hi_byte(hi_byte), .flag(flag), .irq(irq)
    );

    // monitor: compare in the high phase after each edge
    always begin
        @(posedge clk);
        #3;
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_tests++;
            if (lo_byte !== e.lo || hi_byte !== e.hi || flag !== e.fl || irq !== e.iq) begin
                n_fail++;
                $display("FAIL %s: got lo=%h hi=%h flag=%b irq=%b, expected lo=%h hi=%h flag=%b irq=%b",
                         e.tag, lo_byte, hi_byte, flag, irq, e.lo, e.hi, e.fl, e.iq);
            end
        end
    end

    // driver: one cycle of stimulus, pushes expected outputs after the next edge
    task automatic cyc(input logic en, input logic la, input logic ie, input logic cd,
                       input logic [9:0] d, input logic rl, input logic rh,
                       input logic fc, input string tag);
        exp_t e;
        logic [15:0] w;
        logic acc;
        @(negedge clk);
        enable = en; left_adj = la; irq_en = ie; conv_done = cd;
        conv_data = d; rd_lo = rl; rd_hi = rh; flag_clr = fc;
        acc = en && cd && !m_lock && !rl;                       // R3 R4 R5
        if (!en)         m_lock = 1'b0;                         // R9
        else if (!m_lock) m_lock = rl && !rh;                   // R4
        else              m_lock = !rh;                         // R6
        if (!en)      m_flag = 1'b0;                            // R9
        else if (cd)  m_flag = 1'b1;                            // R7
        else if (fc)  m_flag = 1'b0;                            // R8
        if (acc) m_raw = d;
        w = la ? ({6'b0, m_raw} << 6) : {6'b0, m_raw};          // R1 R2
        e.tag = tag; e.lo = w[7:0]; e.hi = w[15:8];
        e.fl = m_flag; e.iq = m_flag & ie;
        sb.push_back(e);
    endtask

    task automatic idle(input logic en, input logic la, input logic ie, input string tag);
        cyc(en, la, ie, 1'b0, 10'h0, 1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(0, 0, 0, "R9 reset");
        idle(0, 1, 1, "R9 reset");

        // basic store, both justifications
        cyc(1, 0, 0, 1, 10'h2A5, 0, 0, 0, "R3");
        idle(1, 0, 0, "R1");
        idle(1, 1, 0, "R10");
        cyc(1, 1, 1, 1, 10'h13C, 0, 0, 0, "R2");
        idle(1, 0, 1, "R10");
        foreach (m_raw[i]) begin end
        for (int k = 0; k < 4; k++) begin
            logic [9:0] v;
            v = (k == 0) ? 10'h000 : (k == 1) ? 10'h3FF : (k == 2) ? 10'h200 : 10'h001;
            cyc(1, 0, 0, 1, v, 0, 0, 0, "R1");
            idle(1, 1, 0, "R2");
        end

        // lock and drop
        cyc(1, 0, 0, 1, 10'h0F0, 0, 0, 1, "R8");
        cyc(1, 0, 0, 0, 10'h0, 0, 0, 1, "R8");
        cyc(1, 0, 1, 0, 10'h0, 1, 0, 0, "R4");
        cyc(1, 0, 1, 1, 10'h155, 0, 0, 0, "R5");
        cyc(1, 0, 1, 0, 10'h0, 1, 0, 0, "R5");
        cyc(1, 1, 1, 1, 10'h2AA, 0, 0, 1, "R7");
        cyc(1, 0, 1, 0, 10'h0, 0, 0, 1, "R8");
        cyc(1, 0, 0, 1, 10'h321, 0, 1, 0, "R6");
        cyc(1, 0, 0, 1, 10'h0FF, 0, 0, 0, "R6");
        idle(1, 1, 0, "R6");

        // read high while open, then lock with coincident conversion
        cyc(1, 0, 0, 0, 10'h0, 0, 1, 0, "R6");
        cyc(1, 0, 0, 1, 10'h111, 0, 0, 0, "R6");
        cyc(1, 0, 1, 1, 10'h222, 1, 0, 0, "R4");
        cyc(1, 0, 1, 1, 10'h333, 0, 0, 0, "R4");
        cyc(1, 0, 0, 1, 10'h044, 1, 1, 0, "R6");
        cyc(1, 0, 0, 1, 10'h055, 0, 0, 0, "R3");

        // disable releases, clears, ignores
        cyc(1, 0, 1, 0, 10'h0, 1, 0, 0, "R4");
        cyc(0, 0, 1, 1, 10'h3C3, 0, 0, 0, "R9");
        cyc(0, 0, 1, 1, 10'h1E1, 0, 0, 0, "R9");
        cyc(1, 0, 1, 1, 10'h2D2, 0, 0, 0, "R9");
        idle(1, 1, 1, "R7");
        idle(1, 1, 0, "R7");
        idle(0, 0, 0, "R9");

        repeat (3) @(negedge clk);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule